// File: doc/BRIEF.md
# Byte-addressable general register file

This block is the general register store of a 16-bit processor datapath. It holds four data registers and four pointer/index registers. Two read ports and one write port reach all eight through a 3-bit selector. Each port also has a byte flag and a half flag. On the data registers a port can move a full word or just one byte, either the low byte or the high byte. The pointer/index registers accept only full-word access.

Reads are combinational from the stored state. A write takes effect at the rising clock edge. A request for byte access to a pointer/index register is flagged as illegal, and an illegal write changes nothing.

An instruction pointer sits next to the general registers. None of the three general ports can select it. A sequencer loads it by pulsing a fetch-advance strobe together with the next fetch address. All storage clears to zero on an asynchronous active-low reset.

Top module: `gpr_file`

## Requirements
- R1: After reset, all eight general registers read 0x0000 and the instruction pointer output is 0x0000.
- R2: A word write (byte flag 0) to a data register, codes 0 to 3, stores all 16 bits. A word read of that register returns them on the next cycle.
- R3: A byte write to a data register works as follows. With half flag 0, it replaces bits 7:0 with write-data bits 7:0. With half flag 1, it replaces bits 15:8 with write-data bits 7:0. The other half of the register is unchanged.
- R4: A byte read of a data register returns the selected half in bits 7:0 of the read bus, with bits 15:8 zero. The half flag selects as in R3.
- R5: The pointer/index registers, codes 4 to 7, store and return full 16-bit words through the general ports.
- R6: A byte request (byte flag 1) to codes 4 to 7 raises the illegal flag of that port. For the write port, the flag rises only while write enable is high, and the target register keeps its value. For a read port, the read bus returns 0x0000.
- R7: A read of a register that is written in the same cycle returns the value it held before that write. The new value is returned from the next cycle onward.
- R8: When the advance strobe is high at a clock edge, the instruction pointer takes the next-address input. Otherwise it holds its value.
- R9: The general ports cannot change the instruction pointer. A write to any code leaves the instruction pointer unchanged.
- R10: The two read ports select independently and return different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_sel | input | 3 | Read port A register code |
| rd_a_byte | input | 1 | Read port A byte access |
| rd_a_hi | input | 1 | Read port A high-half select |
| rd_a_data | output | 16 | Read port A data |
| rd_a_illegal | output | 1 | Read port A illegal byte request |
| rd_b_sel | input | 3 | Read port B register code |
| rd_b_byte | input | 1 | Read port B byte access |
| rd_b_hi | input | 1 | Read port B high-half select |
| rd_b_data | output | 16 | Read port B data |
| rd_b_illegal | output | 1 | Read port B illegal byte request |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 3 | Write register code |
| wr_byte | input | 1 | Write byte access |
| wr_hi | input | 1 | Write high-half select |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| wr_illegal | output | 1 | Illegal write request, write suppressed |
| ip_adv | input | 1 | Fetch-advance strobe |
| ip_next | input | 16 | Next fetch address |
| ip_q | output | 16 | Instruction pointer |

## Verification
Three kinds of activity can fall in the same cycle: a write and a read of the same register, a general-port write and an instruction-pointer advance, and two reads of different registers. The bench provokes the first case by driving a word write and a read of the same code in one cycle. It expects the old value in that cycle and the new value in the following cycle. It provokes the second case by writing every code while the strobe is held low and then while it is pulsed. The instruction pointer must then follow only the strobe and the next-address input.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    LANE_WORD = 2'd0,
    LANE_LO   = 2'd1,
    LANE_HI   = 2'd2,
    LANE_BAD  = 2'd3
  } lane_e;

  function automatic lane_e lane_of(input logic is_byte, input logic hi, input logic bad);
    if (bad)           return LANE_BAD;
    else if (!is_byte) return LANE_WORD;
    else if (hi)       return LANE_HI;
    else               return LANE_LO;
  endfunction

endpackage

// File: rtl/gpr_decode.sv
module gpr_decode
  import gpr_pkg::*;
#(
  parameter int N_DATA = 4,
  parameter int N_REG  = 8,
  parameter int SEL_W  = 3
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             is_byte,
  input  logic             hi,
  output lane_e            lane,
  output logic             bad
);
  logic in_ptr_group;
  logic out_of_range;

  assign in_ptr_group = (32'(sel) >= N_DATA);
  assign out_of_range = (32'(sel) >= N_REG);
  assign bad          = (is_byte & in_ptr_group) | out_of_range;
  assign lane         = lane_of(is_byte, hi, bad);
endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
  import gpr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_REG  = 8,
  parameter int SEL_W  = 3,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [N_REG-1:0][DATA_W-1:0] regs,
  input  logic [SEL_W-1:0]             sel,
  input  lane_e                        lane,
  output logic [DATA_W-1:0]            data
);
  function automatic logic [DATA_W-1:0] extract(input logic [DATA_W-1:0] w, input lane_e ln);
    case (ln)
      LANE_WORD: return w;
      LANE_LO:   return {{HALF_W{1'b0}}, w[HALF_W-1:0]};
      LANE_HI:   return {{HALF_W{1'b0}}, w[DATA_W-1:HALF_W]};
      default:   return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < N_REG; i++) begin
      if (32'(sel) == i) picked = regs[i];
    end
  end

  assign data = extract(picked, lane);
endmodule

// File: rtl/gpr_ip_reg.sv
module gpr_ip_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [DATA_W-1:0] next_addr,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (adv) q <= next_addr;
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_DATA = 4,
  parameter int N_PTR  = 4,
  localparam int N_REG  = N_DATA + N_PTR,
  localparam int SEL_W  = $clog2(N_REG),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  rd_a_sel,
  input  logic              rd_a_byte,
  input  logic              rd_a_hi,
  output logic [DATA_W-1:0] rd_a_data,
  output logic              rd_a_illegal,
  input  logic [SEL_W-1:0]  rd_b_sel,
  input  logic              rd_b_byte,
  input  logic              rd_b_hi,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              rd_b_illegal,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_byte,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal,
  input  logic              ip_adv,
  input  logic [DATA_W-1:0] ip_next,
  output logic [DATA_W-1:0] ip_q
);
  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
                                              input logic [DATA_W-1:0] new_w,
                                              input lane_e ln);
    case (ln)
      LANE_WORD: return new_w;
      LANE_LO:   return {old_w[DATA_W-1:HALF_W], new_w[HALF_W-1:0]};
      LANE_HI:   return {new_w[HALF_W-1:0], old_w[HALF_W-1:0]};
      default:   return old_w;
    endcase
  endfunction

  logic [N_REG-1:0][DATA_W-1:0] reg_q;

  // write path
  lane_e wr_lane;
  logic  wr_bad;
  logic  wr_commit;

  gpr_decode #(.N_DATA(N_DATA), .N_REG(N_REG), .SEL_W(SEL_W)) u_wdec (
    .sel(wr_sel), .is_byte(wr_byte), .hi(wr_hi), .lane(wr_lane), .bad(wr_bad)
  );

  assign wr_illegal = wr_en & wr_bad;
  assign wr_commit  = wr_en & ~wr_bad;

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic hit;
    assign hit = wr_commit && (32'(wr_sel) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   reg_q[i] <= '0;
      else if (hit) reg_q[i] <= merge(reg_q[i], wr_data, wr_lane);
    end
  end

  // read paths
  logic [1:0][SEL_W-1:0]  rp_sel;
  logic [1:0]             rp_byte;
  logic [1:0]             rp_hi;
  logic [1:0][DATA_W-1:0] rp_data;
  logic [1:0]             rp_bad;

  assign rp_sel  = {rd_b_sel, rd_a_sel};
  assign rp_byte = {rd_b_byte, rd_a_byte};
  assign rp_hi   = {rd_b_hi, rd_a_hi};

  for (genvar p = 0; p < 2; p++) begin : g_rp
    lane_e lane;
    gpr_decode #(.N_DATA(N_DATA), .N_REG(N_REG), .SEL_W(SEL_W)) u_dec (
      .sel(rp_sel[p]), .is_byte(rp_byte[p]), .hi(rp_hi[p]), .lane(lane), .bad(rp_bad[p])
    );
    gpr_rd_port #(.DATA_W(DATA_W), .N_REG(N_REG), .SEL_W(SEL_W)) u_rd (
      .regs(reg_q), .sel(rp_sel[p]), .lane(lane), .data(rp_data[p])
    );
  end

  assign rd_a_data    = rp_data[0];
  assign rd_b_data    = rp_data[1];
  assign rd_a_illegal = rp_bad[0];
  assign rd_b_illegal = rp_bad[1];

  // instruction pointer, sequencer port only
  gpr_ip_reg #(.DATA_W(DATA_W)) u_ip (
    .clk(clk), .rst_n(rst_n), .adv(ip_adv), .next_addr(ip_next), .q(ip_q)
  );
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_a_byte,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              rd_a_illegal,
  input logic              rd_b_byte,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              rd_b_illegal,
  input logic              wr_illegal,
  input logic              wr_commit,
  input logic              ip_adv,
  input logic [DATA_W-1:0] ip_next,
  input logic [DATA_W-1:0] ip_q
);
  localparam int HALF_W = DATA_W / 2;

  p_zero_ext_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_byte |-> rd_a_data[DATA_W-1:HALF_W] == '0);

  p_zero_ext_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_byte |-> rd_b_data[DATA_W-1:HALF_W] == '0);

  p_bad_read_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_illegal |-> rd_a_data == '0);

  p_bad_read_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_illegal |-> rd_b_data == '0);

  p_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |-> !wr_commit);

  p_ip_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ip_adv |=> ip_q == $past(ip_next));

  p_ip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ip_adv |=> $stable(ip_q));
endmodule

bind gpr_file gpr_file_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_a_byte(rd_a_byte), .rd_a_data(rd_a_data), .rd_a_illegal(rd_a_illegal),
  .rd_b_byte(rd_b_byte), .rd_b_data(rd_b_data), .rd_b_illegal(rd_b_illegal),
  .wr_illegal(wr_illegal), .wr_commit(wr_commit),
  .ip_adv(ip_adv), .ip_next(ip_next), .ip_q(ip_q)
);

// File: tb/gpr_file_bench.sv
module gpr_file_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic        rd_a_byte = 1'b0, rd_a_hi = 1'b0, rd_b_byte = 1'b0, rd_b_hi = 1'b0;
  logic        wr_en = 1'b0, wr_byte = 1'b0, wr_hi = 1'b0, ip_adv = 1'b0;
  logic [15:0] wr_data = '0, ip_next = '0;
  logic [15:0] rd_a_data, rd_b_data, ip_q;
  logic        rd_a_illegal, rd_b_illegal, wr_illegal;

  always #(CLK_P/2) clk = ~clk;

  gpr_file u_gpr_file (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(rd_a_sel), .rd_a_byte(rd_a_byte), .rd_a_hi(rd_a_hi),
    .rd_a_data(rd_a_data), .rd_a_illegal(rd_a_illegal),
    .rd_b_sel(rd_b_sel), .rd_b_byte(rd_b_byte), .rd_b_hi(rd_b_hi),
    .rd_b_data(rd_b_data), .rd_b_illegal(rd_b_illegal),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_hi(wr_hi),
    .wr_data(wr_data), .wr_illegal(wr_illegal),
    .ip_adv(ip_adv), .ip_next(ip_next), .ip_q(ip_q)
  );

  // scoreboard
  typedef struct {
    string       req;
    int          kind;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // independent model
  logic [15:0] m_reg [8];
  logic [15:0] m_ip;

  function automatic logic m_bad(input logic [2:0] s, input logic b);
    return b && (s >= 3'd4);
  endfunction

  function automatic logic [15:0] m_read(input logic [2:0] s, input logic b, input logic h);
    logic [15:0] w;
    w = m_reg[s];
    if (m_bad(s, b)) return 16'h0000;
    if (!b)          return w;
    if (h)           return {8'h00, w[15:8]};
    return {8'h00, w[7:0]};
  endfunction

  function automatic logic [15:0] observe(input int kind);
    case (kind)
      0: return rd_a_data;
      1: return {15'd0, rd_a_illegal};
      2: return rd_b_data;
      3: return {15'd0, rd_b_illegal};
      4: return {15'd0, wr_illegal};
      default: return ip_q;
    endcase
  endfunction

  function automatic string kind_name(input int kind);
    case (kind)
      0: return "rd_a_data";
      1: return "rd_a_illegal";
      2: return "rd_b_data";
      3: return "rd_b_illegal";
      4: return "wr_illegal";
      default: return "ip_q";
    endcase
  endfunction

  task automatic push(input string req, input int kind, input logic [15:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = q.pop_front();
      got = observe(it.kind);
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s actual=%h expected=%h", it.req, kind_name(it.kind), got, it.exp);
      end
    end
  end

  // driver
  task automatic set_rd(input logic [2:0] sa, input logic ba, input logic ha,
                        input logic [2:0] sb, input logic bb, input logic hb);
    rd_a_sel = sa; rd_a_byte = ba; rd_a_hi = ha;
    rd_b_sel = sb; rd_b_byte = bb; rd_b_hi = hb;
  endtask

  task automatic set_wr(input logic en, input logic [2:0] s, input logic b,
                        input logic h, input logic [15:0] d);
    wr_en = en; wr_sel = s; wr_byte = b; wr_hi = h; wr_data = d;
  endtask

  task automatic go(input string req);
    push(req, 0, m_read(rd_a_sel, rd_a_byte, rd_a_hi));
    push(req, 1, {15'd0, m_bad(rd_a_sel, rd_a_byte)});
    push(req, 2, m_read(rd_b_sel, rd_b_byte, rd_b_hi));
    push(req, 3, {15'd0, m_bad(rd_b_sel, rd_b_byte)});
    push(req, 4, {15'd0, wr_en && m_bad(wr_sel, wr_byte)});
    push(req, 5, m_ip);
    if (wr_en && !m_bad(wr_sel, wr_byte)) begin
      if (!wr_byte)   m_reg[wr_sel] = wr_data;
      else if (wr_hi) m_reg[wr_sel][15:8] = wr_data[7:0];
      else            m_reg[wr_sel][7:0]  = wr_data[7:0];
    end
    if (ip_adv) m_ip = ip_next;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    set_wr(1'b0, 3'd0, 1'b0, 1'b0, 16'h0);
    ip_adv = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 16'h0000;
    m_ip = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R1: reset state of every code and of the instruction pointer
    for (int i = 0; i < 4; i++) begin
      set_rd(3'(i), 1'b0, 1'b0, 3'(i + 4), 1'b0, 1'b0);
      go("R1");
    end

    // R2: word writes to data registers
    set_wr(1'b1, 3'd0, 1'b0, 1'b0, 16'h1234); go("R2");
    set_wr(1'b1, 3'd3, 1'b0, 1'b0, 16'hABCD); go("R2");
    idle(); set_rd(3'd0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0); go("R2");

    // R3: byte writes into each half, other half kept
    set_wr(1'b1, 3'd1, 1'b1, 1'b0, 16'hFF5A); go("R3");
    set_wr(1'b1, 3'd1, 1'b1, 1'b1, 16'h99C3); go("R3");
    set_wr(1'b1, 3'd0, 1'b1, 1'b1, 16'h0077); go("R3");
    idle(); set_rd(3'd1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0); go("R3");

    // R4: byte reads, both halves, zero-extended
    set_rd(3'd3, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0); go("R4");
    set_rd(3'd1, 1'b1, 1'b0, 3'd0, 1'b1, 1'b1); go("R4");

    // R5: pointer/index word access
    for (int i = 4; i < 8; i++) begin
      set_wr(1'b1, 3'(i), 1'b0, 1'b0, 16'(16'hF00D + 16'(i * 16'h0111)));
      go("R5");
    end
    idle();
    set_rd(3'd4, 1'b0, 1'b0, 3'd5, 1'b0, 1'b0); go("R5");
    set_rd(3'd6, 1'b0, 1'b0, 3'd7, 1'b0, 1'b0); go("R5");

    // R6: byte requests to pointer/index codes
    set_wr(1'b1, 3'd5, 1'b1, 1'b0, 16'h0000); go("R6");
    set_wr(1'b1, 3'd7, 1'b1, 1'b1, 16'h00EE); go("R6");
    set_wr(1'b0, 3'd6, 1'b1, 1'b0, 16'h0011); go("R6");
    idle();
    set_rd(3'd5, 1'b0, 1'b0, 3'd7, 1'b0, 1'b0); go("R6");
    set_rd(3'd6, 1'b1, 1'b0, 3'd4, 1'b1, 1'b1); go("R6");

    // R7: write and read of the same register in one cycle
    set_rd(3'd2, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1);
    set_wr(1'b1, 3'd2, 1'b0, 1'b0, 16'h1111); go("R7");
    set_wr(1'b1, 3'd2, 1'b1, 1'b1, 16'h0022); go("R7");
    idle(); go("R7");

    // R8: advance strobe loads, otherwise holds
    ip_next = 16'h0100; ip_adv = 1'b1; go("R8");
    ip_next = 16'h0BAD; ip_adv = 1'b0; go("R8");
    go("R8");
    ip_next = 16'hFFFE; ip_adv = 1'b1; go("R8");
    ip_adv = 1'b0; go("R8");

    // R9: general writes to every code leave the instruction pointer alone
    for (int i = 0; i < 8; i++) begin
      set_wr(1'b1, 3'(i), 1'b0, 1'b0, 16'h5A5A);
      ip_next = 16'h7777;
      go("R9");
    end
    ip_adv = 1'b1; ip_next = 16'h0042;
    set_wr(1'b1, 3'd4, 1'b0, 1'b0, 16'h0042); go("R9");
    idle(); go("R9");

    // R10: independent read ports
    set_wr(1'b1, 3'd0, 1'b0, 1'b0, 16'hC0DE); go("R10");
    set_wr(1'b1, 3'd6, 1'b0, 1'b0, 16'hBEEF); go("R10");
    idle();
    set_rd(3'd0, 1'b0, 1'b0, 3'd6, 1'b0, 1'b0); go("R10");
    set_rd(3'd6, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1); go("R10");

    @(negedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule